// File: doc/BRIEF.md
# Framed Three-Bit Pattern Detector

This block watches a single-bit serial stream that is qualified by a valid strobe. Counting from reset, it splits the accepted bits into back-to-back groups of three that never overlap. When the third bit of a group arrives and the group reads 010 or 110, it raises a one-cycle match pulse in that same cycle. The first bit of every group has no effect on the result. Only the middle bit, which must be 1, and the final bit, which must be 0, decide a match.

The design is a Mealy machine with four states kept in a two-bit register: idle, one bit taken, and two bits taken with a middle bit of 0 or 1. The match output is combinational from the state, the data bit and the strobe. After any third bit the machine goes back to idle.

Top module: `frame3_detector`

## Requirements
- R1: A synchronous active-high reset puts the machine in idle, so the next accepted bit is the first bit of a new group. While reset is high, the match output is 0.
- R2: When valid is high and the accepted bit is the third of its group, match is 1 in that same cycle if and only if the group (first, second, third) is 010 or 110.
- R3: Match is never 1 on the first or second bit of a group.
- R4: The value of the first bit of a group has no effect on the match result for that group.
- R5: When valid is low, match is 0 and the group position is held. The next accepted bit continues the group that was interrupted.
- R6: Groups do not overlap. After the third accepted bit, whatever its value, the next accepted bit starts a new group. A stream such as 0101010 therefore matches only on the third bit.
- R7: The state register holds exactly one of four legal two-bit codes at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bit_vld | input | 1 | Strobe that accepts bit_in in this cycle |
| bit_in | input | 1 | Serial data bit |
| match | output | 1 | One-cycle pulse on a matching third bit (Mealy) |

## Verification
The bench compares against a behavioural model of a group counter and a shift buffer on every clock, and runs four kinds of stimulus:
- All eight three-bit groups, back to back. This shows that only 010 and 110 fire and that the first bit does not matter.
- A repeating 010 pattern that would produce extra hits if detection overlapped. This separates framed matching from sliding-window matching.
- Groups broken up by idle strobe cycles. These show that the group position is held.
- A long random stream with random strobes and a reset in the middle of a group. This checks the realignment that reset causes.

// File: rtl/frame3_pkg.sv
package frame3_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ONE  = 2'b01,
        ST_MID0 = 2'b10,
        ST_MID1 = 2'b11
    } det_state_t;

    typedef struct packed {
        det_state_t st;
    } det_regs_t;
endpackage

// File: rtl/frame3_next.sv
module frame3_next
    import frame3_pkg::*;
(
    input  det_state_t cur,
    input  logic       vld,
    input  logic       din,
    output det_state_t nxt,
    output logic       hit
);
    always_comb begin
        nxt = cur;
        hit = 1'b0;
        if (vld) begin
            unique case (cur)
                ST_IDLE: nxt = ST_ONE;
                ST_ONE:  nxt = din ? ST_MID1 : ST_MID0;
                ST_MID0: nxt = ST_IDLE;
                ST_MID1: begin
                    nxt = ST_IDLE;
                    hit = ~din;
                end
                default: nxt = ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frame3_detector.sv
module frame3_detector
    import frame3_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic bit_vld,
    input  logic bit_in,
    output logic match
);
    det_regs_t  regs_d, regs_q;
    det_state_t st_nxt;
    logic       hit_w;

    frame3_next u_next (
        .cur (regs_q.st),
        .vld (bit_vld),
        .din (bit_in),
        .nxt (st_nxt),
        .hit (hit_w)
    );

    always_comb begin
        regs_d    = regs_q;
        regs_d.st = rst ? ST_IDLE : st_nxt;
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign match = hit_w & ~rst;

    // R1
    reset_idle_chk: assert property (@(posedge clk) rst |=> regs_q.st == ST_IDLE);
    // R5
    hold_chk: assert property (@(posedge clk) disable iff (rst) !bit_vld |-> !match);
    // R5
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_vld |=> $stable(regs_q.st));
    // R6
    wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (bit_vld && (regs_q.st == ST_MID0 || regs_q.st == ST_MID1)) |=> regs_q.st == ST_IDLE);
    // R3
    early_chk: assert property (@(posedge clk) disable iff (rst)
        (regs_q.st == ST_IDLE || regs_q.st == ST_ONE) |-> !match);
    // R7
    legal_chk: assert property (@(posedge clk) disable iff (rst)
        !$isunknown(regs_q.st));
endmodule

// File: tb/sim_frame3_detector.sv
module sim_frame3_detector;
    localparam int CLK_PERIOD = 10;
    logic clk = 0, rst = 1, bit_vld = 0, bit_in = 0;
    logic match;
    int checks = 0, failures = 0;
    int pos = 0;
    logic [1:0] buf2 = 0;
    bit done = 0;

    frame3_detector u0 (.clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .match(match));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic model_exp();
        if (rst || !bit_vld || pos != 2) return 1'b0;
        return (buf2[0] == 1'b1) && (bit_in == 1'b0);
    endfunction

    // Sample mid-cycle, before the rising edge; update the model at the edge.
    always @(negedge clk) begin
        logic e;
        e = model_exp();
        checks++;
        if (match !== e) begin
            failures++;
            $display("FAIL R2/R3/R5 pos=%0d vld=%b in=%b actual=%b expected=%b",
                     pos, bit_vld, bit_in, match, e);
        end
    end

    always @(posedge clk) begin
        if (rst) pos <= 0;
        else if (bit_vld) begin
            buf2 <= {buf2[0], bit_in};
            pos  <= (pos == 2) ? 0 : pos + 1;
        end
    end

    task automatic send(input logic v, input logic b);
        bit_vld = v; bit_in = b;
        @(posedge clk); #1;
    endtask

    task automatic expect_now(input logic e, input string tag);
        checks++;
        if (match !== e) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", tag, match, e);
        end
    endtask

    initial begin
        #(CLK_PERIOD*20000);
        failures++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(posedge clk); @(posedge clk); #1;
        bit_vld = 1; bit_in = 1; #1;
        expect_now(1'b0, "R1 reset output");
        rst = 0;
        // R2 R4: all eight groups
        for (int g = 0; g < 8; g++) begin
            bit_vld = 1; bit_in = g[2]; #1;
            expect_now(1'b0, "R3 first bit");
            @(posedge clk); #1;
            bit_in = g[1]; #1;
            expect_now(1'b0, "R3 second bit");
            @(posedge clk); #1;
            bit_in = g[0]; #1;
            expect_now((g == 2 || g == 6), "R2 R4 third bit");
            @(posedge clk); #1;
        end
        // R6 overlapping stream 0101010 then pad: only one hit
        send(1,0); send(1,1);
        bit_in = 0; #1; expect_now(1'b1, "R6 first group hit");
        @(posedge clk); #1;
        send(1,1); send(1,0);
        bit_in = 1; #1; expect_now(1'b0, "R6 no overlap");
        @(posedge clk); #1;
        // R5 gaps
        send(1,1); send(0,0); send(0,1); send(1,1); send(0,1);
        bit_vld = 0; bit_in = 0; #1; expect_now(1'b0, "R5 idle no match");
        bit_vld = 1; #1; expect_now(1'b1, "R5 resumed group");
        @(posedge clk); #1;
        // R1 reset mid group
        send(1,0); send(1,1);
        rst = 1; send(1,0); rst = 0;
        send(1,0); send(1,1);
        bit_in = 0; #1; expect_now(1'b1, "R1 realigned after reset");
        @(posedge clk); #1;
        // random
        for (int i = 0; i < 3000; i++) begin
            rst = ($urandom_range(0,199) == 0);
            send($urandom_range(0,3) != 0, $urandom_range(0,1));
        end
        rst = 0; send(0,0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule